// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block produces the bit-level timing grid for a CAN controller. A programmable prescaler divides the module clock into time quanta. Each bit is then laid out as a synchronisation quantum, a phase segment that ends at the sample point, and a phase segment that follows it. Two single-cycle strobes come out: one marks the first clock of every bit and one marks the sample point.

The timing is set by a 16-bit configuration word. Software can only change it while the controller is in initialisation and configuration changes are enabled. The reset value gives a 500 kbit/s bit rate from an 8 MHz module clock. While initialisation is active, the counters stay cleared and no strobes are produced. When initialisation is released, a new bit starts at once. The jump-width field is stored and can be read back, but this unit does not act on it.

Top module: `can_bit_timing`

## Requirements
- R1: After reset, `cfgRd` reads 16'h2301. This is prescaler 1, jump width 0, pre-sample field 3 and post-sample field 2.
- R2: A write of `wrData` is stored only in a clock where `wrEn`, `ctlCfgEn` and `ctlInit` are all 1. A write in any other clock leaves `cfgRd` unchanged and does not disturb the strobes.
- R3: Bit 15 of the configuration word always reads 0, whatever value is written to it.
- R4: The layout is prescaler in bits [5:0], jump width in [7:6], pre-sample field in [11:8] and post-sample field in [14:12]. A time quantum lasts prescaler+1 clocks. A bit lasts (prescaler+1)·(1+T1+T2) clocks, where T1 = pre-sample field+1 and T2 = post-sample field+1.
- R5: `bitStart` is high for exactly the first clock of every bit. The first such clock is the first clock in which `ctlInit` is 0.
- R6: `samplePoint` is high for one clock: the last clock of the pre-sample segment, which is (prescaler+1)·(1+T1)−1 clocks after `bitStart`. It never coincides with `bitStart`.
- R7: A pre-sample field of 0 is handled as if it were 1, which gives T1 = 2.
- R8: While `ctlInit` is 1, neither strobe is asserted and the bit timing restarts from the beginning of a bit.
- R9: With the reset configuration, a bit lasts 16 clocks and `samplePoint` comes 9 clocks after `bitStart`.
- R10: The jump-width field in bits [7:6] is stored on an accepted write and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlInit | input | 1 | Initialisation state of the controller; holds the timing |
| ctlCfgEn | input | 1 | Configuration change enable |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | 16 | Configuration write data |
| cfgRd | output | 16 | Current configuration word |
| bitStart | output | 1 | One-clock pulse on the first clock of a bit |
| samplePoint | output | 1 | One-clock pulse at the sample point |

## Verification
A configuration write attempt and a running sample point can fall in the same clock. The bench provokes this by holding `wrEn` and `ctlCfgEn` high with junk data for a whole run once initialisation is released, so the attempt also covers the sample-point clocks. It judges the result in two ways: the strobe pattern must match the pattern predicted from the configuration that was accepted earlier, and `cfgRd` must still show that configuration after the run.

// File: rtl/canbt_pkg.sv
package canbt_pkg;
  typedef struct packed {
    logic hold;   // clear both counters
    logic stepQ;  // last clock of a quantum: advance the quantum index
    logic wrapQ;  // last clock of the last quantum: start a new bit
  } btStrobe_t;
endpackage

// File: rtl/canbt_datapath.sv
module canbt_datapath
  import canbt_pkg::*;
#(
  parameter int BRP_W  = 6,
  parameter int QCNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  btStrobe_t         strb,
  input  logic [BRP_W-1:0]  brpLim,
  input  logic [QCNT_W-1:0] qLim,
  output logic [BRP_W-1:0]  prescCnt,
  output logic [QCNT_W-1:0] quantaCnt
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt  <= '0;
      quantaCnt <= '0;
    end else if (strb.hold) begin
      prescCnt  <= '0;
      quantaCnt <= '0;
    end else if (strb.stepQ) begin
      prescCnt  <= '0;
      quantaCnt <= strb.wrapQ ? '0 : quantaCnt + 1'b1;
    end else begin
      prescCnt  <= prescCnt + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    prescCnt <= brpLim); // R4
  AST_QCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    quantaCnt < qLim); // R4
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.hold |=> (prescCnt == '0 && quantaCnt == '0)); // R8
  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrapQ |=> (prescCnt == '0 && quantaCnt == '0)); // R5

endmodule

// File: rtl/canbt_ctrl.sv
module canbt_ctrl
  import canbt_pkg::*;
#(
  parameter int              BRP_W   = 6,
  parameter int              SJW_W   = 2,
  parameter int              TS1_W   = 4,
  parameter int              TS2_W   = 3,
  parameter int              REG_W   = 16,
  parameter int              QCNT_W  = 5,
  parameter logic [REG_W-1:0] RST_VAL = 16'h2301
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlInit,
  input  logic              ctlCfgEn,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic [BRP_W-1:0]  prescCnt,
  input  logic [QCNT_W-1:0] quantaCnt,
  output btStrobe_t         strb,
  output logic [BRP_W-1:0]  brpLim,
  output logic [QCNT_W-1:0] qLim,
  output logic [REG_W-1:0]  cfgRd,
  output logic              bitStart,
  output logic              samplePoint
);

  localparam int SJW_LSB = BRP_W;
  localparam int TS1_LSB = SJW_LSB + SJW_W;
  localparam int TS2_LSB = TS1_LSB + TS1_W;
  localparam int USED_W  = TS2_LSB + TS2_W;
  localparam int PAD_W   = REG_W - USED_W;

  logic [REG_W-1:0]  cfgReg;
  logic              wrOk;
  logic [TS1_W-1:0]  ts1Fld;
  logic [TS2_W-1:0]  ts2Fld;
  logic [QCNT_W-1:0] t1Q;
  logic [QCNT_W-1:0] t2Q;
  logic              prescLast;

  assign wrOk = wrEn & ctlCfgEn & ctlInit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cfgReg <= {{PAD_W{1'b0}}, RST_VAL[USED_W-1:0]};
    else if (wrOk) cfgReg <= {{PAD_W{1'b0}}, wrData[USED_W-1:0]};
  end

  assign cfgRd  = cfgReg;
  assign brpLim = cfgReg[BRP_W-1:0];
  assign ts1Fld = cfgReg[TS1_LSB +: TS1_W];
  assign ts2Fld = cfgReg[TS2_LSB +: TS2_W];

  // pre-sample field of 0 is promoted to 1, then each segment adds one
  always_comb begin
    if (ts1Fld == '0) t1Q = QCNT_W'(2);
    else              t1Q = QCNT_W'(ts1Fld) + QCNT_W'(1);
    t2Q  = QCNT_W'(ts2Fld) + QCNT_W'(1);
    qLim = QCNT_W'(1) + t1Q + t2Q;
  end

  assign prescLast  = (prescCnt == brpLim);
  assign strb.hold  = ctlInit;
  assign strb.stepQ = !ctlInit && prescLast;
  assign strb.wrapQ = strb.stepQ && (quantaCnt == qLim - QCNT_W'(1));

  assign bitStart    = !ctlInit && (prescCnt == '0) && (quantaCnt == '0);
  assign samplePoint = !ctlInit && prescLast && (quantaCnt == t1Q);

  AST_WR_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && ctlCfgEn && ctlInit) |=> $stable(cfgRd)); // R2
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(bitStart && samplePoint)); // R6
  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    samplePoint |=> !samplePoint); // R6
  AST_CFG_FROZEN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !ctlInit |=> $stable(qLim)); // R2

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import canbt_pkg::*;
#(
  parameter int               BRP_W   = 6,
  parameter int               SJW_W   = 2,
  parameter int               TS1_W   = 4,
  parameter int               TS2_W   = 3,
  parameter int               REG_W   = 16,
  parameter logic [REG_W-1:0] RST_VAL = 16'h2301
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlInit,
  input  logic             ctlCfgEn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] cfgRd,
  output logic             bitStart,
  output logic             samplePoint
);

  localparam int MAX_Q  = 1 + (1 << TS1_W) + (1 << TS2_W);
  localparam int QCNT_W = $clog2(MAX_Q + 1);

  btStrobe_t         strb;
  logic [BRP_W-1:0]  brpLim;
  logic [QCNT_W-1:0] qLim;
  logic [BRP_W-1:0]  prescCnt;
  logic [QCNT_W-1:0] quantaCnt;

  canbt_ctrl #(
    .BRP_W(BRP_W), .SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W),
    .REG_W(REG_W), .QCNT_W(QCNT_W), .RST_VAL(RST_VAL)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .ctlInit(ctlInit), .ctlCfgEn(ctlCfgEn),
    .wrEn(wrEn), .wrData(wrData), .prescCnt(prescCnt), .quantaCnt(quantaCnt),
    .strb(strb), .brpLim(brpLim), .qLim(qLim), .cfgRd(cfgRd),
    .bitStart(bitStart), .samplePoint(samplePoint)
  );

  canbt_datapath #(.BRP_W(BRP_W), .QCNT_W(QCNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .brpLim(brpLim), .qLim(qLim),
    .prescCnt(prescCnt), .quantaCnt(quantaCnt)
  );

endmodule

// File: tb/test_can_bit_timing.sv
module test_can_bit_timing;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlInit = 1'b1;
  logic ctlCfgEn = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] cfgRd;
  logic bitStart, samplePoint;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  can_bit_timing i_can_bit_timing (
    .clk(clk), .rstN(rstN), .ctlInit(ctlInit), .ctlCfgEn(ctlCfgEn),
    .wrEn(wrEn), .wrData(wrData), .cfgRd(cfgRd),
    .bitStart(bitStart), .samplePoint(samplePoint)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int t1Of(input logic [15:0] c);
    return (c[11:8] == 0) ? 2 : int'(c[11:8]) + 1;
  endfunction
  function automatic int periodOf(input logic [15:0] c);
    return (int'(c[5:0]) + 1) * (1 + t1Of(c) + int'(c[14:12]) + 1);
  endfunction
  function automatic int spOf(input logic [15:0] c);
    return (int'(c[5:0]) + 1) * (1 + t1Of(c)) - 1;
  endfunction

  task automatic doWrite(input logic init, input logic en, input logic [15:0] d);
    @(posedge clk); #1;
    ctlInit = init; ctlCfgEn = en; wrEn = 1'b1; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  // hold init, then release and compare strobes with the prediction
  task automatic runTiming(input logic [15:0] c, input bit junkWr, input string tag);
    int p, sp, errB, errS, firstB, firstS;
    p = periodOf(c); sp = spOf(c);
    errB = 0; errS = 0; firstB = -1; firstS = -1;
    @(posedge clk); #1; ctlInit = 1'b1; wrEn = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (bitStart || samplePoint) errB++;
    end
    check(errB == 0, {"R8 quiet in init ", tag}, errB, 0);
    errB = 0;
    @(posedge clk); #1;
    ctlInit = 1'b0;
    if (junkWr) begin ctlCfgEn = 1'b1; wrEn = 1'b1; wrData = ~c; end
    else ctlCfgEn = 1'b0;
    for (int cyc = 0; cyc < 2 * p + 3; cyc++) begin
      @(negedge clk);
      if (bitStart !== ((cyc % p) == 0)) begin errB++; if (firstB < 0) firstB = cyc; end
      if (samplePoint !== ((cyc % p) == sp)) begin errS++; if (firstS < 0) firstS = cyc; end
    end
    check(errB == 0, {"R4 R5 bitStart pattern ", tag}, firstB, -1);
    check(errS == 0, {"R6 samplePoint pattern ", tag}, firstS, -1);
    @(posedge clk); #1; wrEn = 1'b0; ctlCfgEn = 1'b0; ctlInit = 1'b1;
    if (junkWr) begin
      @(negedge clk);
      check(cfgRd == c, "R2 write during run ignored", cfgRd, c);
    end
  endtask

  task automatic loadCfg(input logic [15:0] d, input string req);
    logic [15:0] e;
    e = {1'b0, d[14:0]};
    doWrite(1'b1, 1'b1, d);
    @(negedge clk);
    check(cfgRd == e, req, cfgRd, e);
  endtask

  initial begin
    logic [15:0] c, prev;
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(cfgRd == 16'h2301, "R1 reset value", cfgRd, 16'h2301);
    check(!bitStart && !samplePoint, "R8 no strobes after reset in init",
          {bitStart, samplePoint}, 0);

    runTiming(16'h2301, 1'b0, "R9 reset config");
    check(periodOf(16'h2301) == 16 && spOf(16'h2301) == 9, "R9 bench model", 0, 0);

    // protection: missing one of the two enables
    doWrite(1'b1, 1'b0, 16'h1234); @(negedge clk);
    check(cfgRd == 16'h2301, "R2 no cfg enable", cfgRd, 16'h2301);
    doWrite(1'b0, 1'b1, 16'h4567); @(negedge clk);
    check(cfgRd == 16'h2301, "R2 not in init", cfgRd, 16'h2301);
    doWrite(1'b0, 1'b0, 16'h0F0F); @(negedge clk);
    check(cfgRd == 16'h2301, "R2 neither enable", cfgRd, 16'h2301);

    // directed corners
    loadCfg(16'hFFFF, "R3 bit 15 reads zero");
    loadCfg(16'h00C0, "R10 jump width readback; R7 field 0");
    runTiming(16'h00C0, 1'b0, "R7 pre-sample 0");
    loadCfg(16'h7F00, "R4 max segments");
    runTiming(16'h7F00, 1'b1, "R4 max segments, R2 junk write");
    loadCfg(16'h0107, "R4 short bit");
    runTiming(16'h0107, 1'b0, "R4 short bit");

    // constrained random configurations
    for (int n = 0; n < 16; n++) begin
      c = 16'($urandom);
      c[5:3] = 3'b000;
      prev = c;
      loadCfg(c, "R2 R3 R10 random write");
      c = {1'b0, prev[14:0]};
      runTiming(c, (n % 3) == 0, "random");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule